// File: doc/BRIEF.md
# Validated Receive Buffer with Commit DMA and Host Arbitration

This block sits between a serial message receiver and a shared word-wide main RAM. The words of one message are collected in a small staging buffer. They reach RAM only once the whole message has been declared good. A message that is aborted or rejected leaves RAM untouched, so the host never sees partial or corrupt data.

A committed message starts a fixed-length active-low command strobe. The command word is queued in a command FIFO that the host drains. When the strobe ends, a paced DMA burst moves the staged words into RAM. A transmit message runs the burst the other way, from RAM into the buffer, and the outgoing words are then read out in order.

A single host port shares the RAM with the DMA through a request/acknowledge handshake. A request that was already waiting when the strobe began is still granted during the strobe. A request raised after the strobe began waits until the burst has finished.

Top module: `rxCommitBuffer`

## Requirements
- R1: After reset `cmdStrobeN` and `hostAckN` are 1, `fifoNotEmpty` is 0 and `fifoNotFull` is 1.
- R2: Receive words are held in arrival order. After a commit, word i lands at RAM address {cmdWord[7:5], i[4:0]}. A message ended by `msgAbort` leaves RAM unchanged and produces no strobe.
- R3: If `illegalN` is 0 in the cycle `msgDone` is sampled, the message produces no strobe, no FIFO entry and no RAM change.
- R4: `cmdStrobeN` goes low in the cycle after `msgDone` is sampled and stays low for exactly 136 cycles. The DMA burst then moves one word per 16-cycle slot, and each word is written at the end of its slot.
- R5: A host request that is granted pulls `hostAckN` low for exactly 8 cycles, starting the cycle after the grant. A request already pending when the strobe starts is granted while the strobe is still low.
- R6: A host request raised after the strobe has started is not acknowledged until the burst is over. For an n-word burst, the grant comes one cycle after the last word slot.
- R7: A committed command is pushed into a 32-entry FIFO at strobe start and `fifoNotEmpty` goes to 1. When 32 entries are held, `fifoNotFull` is 0 and further pushes are dropped.
- R8: A command with `cmdHasData` = 0 produces no strobe and no FIFO entry.
- R9: A host read of address 0 returns the oldest FIFO entry and removes it. On an empty FIFO the read returns 0 and changes nothing.
- R10: A transmit command (`cmdIsRx` = 0) copies cmdWord[4:0] words (0 meaning 32) from RAM block cmdWord[7:5] into the buffer after the strobe. `txData` shows buffer word 0 first and advances on each `txNext`.
- R11: A host read or write at a non-zero address accesses that RAM word directly while no strobe or burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command word present; starts a message |
| cmdWord | input | 16 | Command word (block in [7:5], transmit count in [4:0]) |
| cmdIsRx | input | 1 | 1 receive, 0 transmit |
| cmdHasData | input | 1 | Command carries data words |
| wordValid | input | 1 | Incoming data word present |
| wordIn | input | 16 | Incoming data word |
| msgDone | input | 1 | Message complete and validated |
| msgAbort | input | 1 | Message failed; flush |
| illegalN | input | 1 | Active-low illegalise, sampled with msgDone |
| hostReq | input | 1 | Host access request, held until acknowledged |
| hostWe | input | 1 | Host write (1) or read (0) |
| hostAddr | input | 8 | Host word address; 0 is the FIFO |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data, valid while acknowledged |
| hostAckN | output | 1 | Active-low acknowledge pulse |
| txNext | input | 1 | Advance transmit read pointer |
| txData | output | 16 | Current transmit buffer word |
| cmdStrobeN | output | 1 | Active-low command strobe |
| fifoNotEmpty | output | 1 | FIFO holds at least one entry |
| fifoNotFull | output | 1 | FIFO can accept an entry |

## Verification
The hardest case to reach is a host request that is pending, but not yet granted, at the moment the strobe starts. An idle RAM grants any request in the very next cycle, so this case cannot be hit by simply raising a request. The stimulus therefore makes one host access, drops the request, and raises a second one in the same cycle as `msgDone`. The acknowledge counter of the first access is still running, so the second request is held back. It is then expected to be granted while `cmdStrobeN` is still low. A companion case raises a request just after the strobe falls and counts the cycles to its acknowledge, which checks the strobe length, the per-word pacing and the hold-off together.

// File: rtl/rbcPkg.sv
package rbcPkg;
  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic cmdLoad;
    logic bufWr;
    logic fifoPush;
    logic hostGo;
    logic dmaStep;
    logic dmaToRam;
  } ctlStrobes_t;

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_STROBE, ST_DMA} ctlState_t;
endpackage

// File: rtl/rbcCmdFifo.sv
module rbcCmdFifo #(
  parameter int DEPTH = 32,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [PW:0]   count;
  logic          popEff, pushEff;

  assign empty   = (count == '0);
  assign full    = (count == (PW+1)'(DEPTH));
  assign popEff  = pop && !empty;
  assign pushEff = push && (!full || popEff);
  assign dout    = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushEff) begin
        mem[wrPtr] <= din;
        wrPtr <= (wrPtr == PW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      end
      if (popEff)
        rdPtr <= (rdPtr == PW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      if (pushEff && !popEff)
        count <= count + 1'b1;
      else if (popEff && !pushEff)
        count <= count - 1'b1;
    end
  end

  // R7: a push into a full FIFO without a pop leaves it full
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && full) |=> full);
  // R9: popping an empty FIFO without a push keeps it empty
  a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/rbcDatapath.sv
module rbcDatapath import rbcPkg::*; #(
  parameter int BUF_DEPTH  = 32,
  parameter int RAM_AW     = 8,
  parameter int W          = 16,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  ctl,
  input  logic [$clog2(BUF_DEPTH)-1:0] wrIdx,
  input  logic [$clog2(BUF_DEPTH)-1:0] dmaIdx,
  input  logic [W-1:0]                 wordIn,
  input  logic [W-1:0]                 cmdWord,
  input  logic                         hostWe,
  input  logic [RAM_AW-1:0]            hostAddr,
  input  logic [W-1:0]                 hostWdata,
  input  logic                         txNext,
  output logic [W-1:0]                 hostRdata,
  output logic [W-1:0]                 txData,
  output logic                         fifoNotEmpty,
  output logic                         fifoNotFull
);
  localparam int IDX_W     = $clog2(BUF_DEPTH);
  localparam int BLK_W     = RAM_AW - IDX_W;
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [W-1:0]      bufMem [BUF_DEPTH];
  logic [W-1:0]      ram    [RAM_DEPTH];
  logic [BLK_W-1:0]  blkReg;
  logic [IDX_W-1:0]  txIdx;
  logic [RAM_AW-1:0] dmaAddr;
  logic              hostIsFifo, fifoPop, fifoEmpty, fifoFull;
  logic [W-1:0]      fifoHead;

  assign dmaAddr    = {blkReg, dmaIdx};
  assign hostIsFifo = (hostAddr == '0);
  assign fifoPop    = ctl.hostGo && !hostWe && hostIsFifo;
  assign txData     = bufMem[txIdx];
  assign fifoNotEmpty = !fifoEmpty;
  assign fifoNotFull  = !fifoFull;

  rbcCmdFifo #(.DEPTH(FIFO_DEPTH), .W(W)) uFifo (
    .clk(clk), .rstN(rstN), .push(ctl.fifoPush), .pop(fifoPop),
    .din(cmdWord), .dout(fifoHead), .empty(fifoEmpty), .full(fifoFull)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_DEPTH; i++) bufMem[i] <= '0;
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
      blkReg    <= '0;
      txIdx     <= '0;
      hostRdata <= '0;
    end else begin
      if (ctl.cmdLoad) begin
        blkReg <= cmdWord[IDX_W +: BLK_W];
        txIdx  <= '0;
      end else if (txNext) begin
        txIdx <= txIdx + 1'b1;
      end
      if (ctl.bufWr)
        bufMem[wrIdx] <= wordIn;
      if (ctl.dmaStep && !ctl.dmaToRam)
        bufMem[dmaIdx] <= ram[dmaAddr];
      if (ctl.dmaStep && ctl.dmaToRam)
        ram[dmaAddr] <= bufMem[dmaIdx];
      if (ctl.hostGo) begin
        if (hostWe && !hostIsFifo)
          ram[hostAddr] <= hostWdata;
        if (!hostWe)
          hostRdata <= hostIsFifo ? (fifoEmpty ? '0 : fifoHead) : ram[hostAddr];
      end
    end
  end

  // R6: the host never touches RAM in a cycle where the burst moves a word
  a_r6_dma_host_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.dmaStep && ctl.hostGo));
endmodule

// File: rtl/rbcControl.sv
module rbcControl import rbcPkg::*; #(
  parameter int BUF_DEPTH  = 32,
  parameter int STROBE_CYC = 136,
  parameter int ACK_CYC    = 8,
  parameter int WORD_CYC   = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cmdValid,
  input  logic                         cmdIsRx,
  input  logic                         cmdHasData,
  input  logic [$clog2(BUF_DEPTH)-1:0] cmdCount,
  input  logic                         wordValid,
  input  logic                         msgDone,
  input  logic                         msgAbort,
  input  logic                         illegalN,
  input  logic                         hostReq,
  output ctlStrobes_t                  ctl,
  output logic [$clog2(BUF_DEPTH)-1:0] wrIdx,
  output logic [$clog2(BUF_DEPTH)-1:0] dmaIdx,
  output logic                         cmdStrobeN,
  output logic                         hostAckN
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = IDX_W + 1;
  localparam int SC_W  = $clog2(STROBE_CYC);
  localparam int WC_W  = $clog2(WORD_CYC);
  localparam int AC_W  = $clog2(ACK_CYC + 1);
  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(BUF_DEPTH);

  ctlState_t         state;
  logic              isRx, hasData, served, earlyOk;
  logic [CNT_W-1:0]  rxCnt, txLen, dmaLen;
  logic [SC_W-1:0]   strobeCnt;
  logic [WC_W-1:0]   wordTmr;
  logic [IDX_W-1:0]  dmaIdxQ;
  logic [AC_W-1:0]   ackCnt;
  logic              hostFree, newReq, inCollect, commit;

  assign hostFree  = (state == ST_IDLE) || (state == ST_COLLECT);
  assign inCollect = (state == ST_COLLECT);
  assign newReq    = hostReq && !served && (ackCnt == '0);
  assign dmaLen    = isRx ? rxCnt : txLen;
  assign commit    = inCollect && !cmdValid && !msgAbort && msgDone && illegalN && hasData;

  always_comb begin
    ctl          = '0;
    ctl.cmdLoad  = cmdValid && hostFree;
    ctl.bufWr    = inCollect && !cmdValid && !msgDone && !msgAbort &&
                   isRx && wordValid && (rxCnt < FULL_LEN);
    ctl.fifoPush = commit;
    ctl.hostGo   = newReq && (hostFree || (state == ST_STROBE && earlyOk));
    ctl.dmaStep  = (state == ST_DMA) && (wordTmr == '0);
    ctl.dmaToRam = isRx;
  end

  assign wrIdx      = rxCnt[IDX_W-1:0];
  assign dmaIdx     = dmaIdxQ;
  assign cmdStrobeN = (state != ST_STROBE);
  assign hostAckN   = (ackCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      isRx      <= 1'b0;
      hasData   <= 1'b0;
      rxCnt     <= '0;
      txLen     <= '0;
      strobeCnt <= '0;
      wordTmr   <= '0;
      dmaIdxQ   <= '0;
      served    <= 1'b0;
      earlyOk   <= 1'b0;
      ackCnt    <= '0;
    end else begin
      if (ctl.cmdLoad) begin
        state   <= ST_COLLECT;
        isRx    <= cmdIsRx;
        hasData <= cmdHasData;
        rxCnt   <= '0;
        txLen   <= (cmdCount == '0) ? FULL_LEN : {1'b0, cmdCount};
      end else begin
        case (state)
          ST_COLLECT: begin
            if (msgAbort) state <= ST_IDLE;
            else if (msgDone) begin
              if (commit) begin
                state     <= ST_STROBE;
                strobeCnt <= SC_W'(STROBE_CYC - 1);
                earlyOk   <= hostReq && !served;
              end else state <= ST_IDLE;
            end else if (ctl.bufWr) rxCnt <= rxCnt + 1'b1;
          end
          ST_STROBE: begin
            if (strobeCnt == '0) begin
              earlyOk <= 1'b0;
              dmaIdxQ <= '0;
              wordTmr <= WC_W'(WORD_CYC - 1);
              state   <= (dmaLen == '0) ? ST_IDLE : ST_DMA;
            end else strobeCnt <= strobeCnt - 1'b1;
          end
          ST_DMA: begin
            if (wordTmr == '0) begin
              if ({1'b0, dmaIdxQ} == dmaLen - 1'b1) state <= ST_IDLE;
              else begin
                dmaIdxQ <= dmaIdxQ + 1'b1;
                wordTmr <= WC_W'(WORD_CYC - 1);
              end
            end else wordTmr <= wordTmr - 1'b1;
          end
          default: ;
        endcase
      end
      // host handshake (after state logic so a grant clears earlyOk)
      if (ctl.hostGo) begin
        served  <= 1'b1;
        ackCnt  <= AC_W'(ACK_CYC);
        earlyOk <= 1'b0;
      end else begin
        if (ackCnt != '0) ackCnt <= ackCnt - 1'b1;
        if (!hostReq) served <= 1'b0;
      end
    end
  end

  // Checker counters for pulse-length properties
  logic [15:0] strobeRun, ackRun;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeRun <= '0;
      ackRun    <= '0;
    end else begin
      strobeRun <= cmdStrobeN ? '0 : strobeRun + 1'b1;
      ackRun    <= hostAckN ? '0 : ackRun + 1'b1;
    end
  end

  // R4: strobe low for exactly STROBE_CYC cycles
  a_r4_strobe_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdStrobeN) |-> strobeRun == 16'(STROBE_CYC));
  // R5: acknowledge low for exactly ACK_CYC cycles
  a_r5_ack_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostAckN) |-> ackRun == 16'(ACK_CYC));
  // R6: no acknowledge starts from a grant made during the burst
  a_r6_no_grant_in_dma: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostAckN) |-> $past(state) != ST_DMA);
  // R3 / R8: a strobe only follows a legal message that carries data
  a_r3_strobe_legal: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdStrobeN) |-> ($past(illegalN) && hasData));
endmodule

// File: rtl/rxCommitBuffer.sv
module rxCommitBuffer import rbcPkg::*; #(
  parameter int BUF_DEPTH  = 32,
  parameter int RAM_AW     = 8,
  parameter int W          = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int STROBE_CYC = 136,
  parameter int ACK_CYC    = 8,
  parameter int WORD_CYC   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [W-1:0]      cmdWord,
  input  logic              cmdIsRx,
  input  logic              cmdHasData,
  input  logic              wordValid,
  input  logic [W-1:0]      wordIn,
  input  logic              msgDone,
  input  logic              msgAbort,
  input  logic              illegalN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [RAM_AW-1:0] hostAddr,
  input  logic [W-1:0]      hostWdata,
  output logic [W-1:0]      hostRdata,
  output logic              hostAckN,
  input  logic              txNext,
  output logic [W-1:0]      txData,
  output logic              cmdStrobeN,
  output logic              fifoNotEmpty,
  output logic              fifoNotFull
);
  localparam int IDX_W = $clog2(BUF_DEPTH);

  ctlStrobes_t      ctl;
  logic [IDX_W-1:0] wrIdx, dmaIdx;

  rbcControl #(.BUF_DEPTH(BUF_DEPTH), .STROBE_CYC(STROBE_CYC),
               .ACK_CYC(ACK_CYC), .WORD_CYC(WORD_CYC)) uCtl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsRx(cmdIsRx),
    .cmdHasData(cmdHasData), .cmdCount(cmdWord[IDX_W-1:0]),
    .wordValid(wordValid), .msgDone(msgDone), .msgAbort(msgAbort),
    .illegalN(illegalN), .hostReq(hostReq), .ctl(ctl), .wrIdx(wrIdx),
    .dmaIdx(dmaIdx), .cmdStrobeN(cmdStrobeN), .hostAckN(hostAckN)
  );

  rbcDatapath #(.BUF_DEPTH(BUF_DEPTH), .RAM_AW(RAM_AW), .W(W),
                .FIFO_DEPTH(FIFO_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrIdx(wrIdx), .dmaIdx(dmaIdx),
    .wordIn(wordIn), .cmdWord(cmdWord), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .txNext(txNext), .hostRdata(hostRdata),
    .txData(txData), .fifoNotEmpty(fifoNotEmpty), .fifoNotFull(fifoNotFull)
  );
endmodule

// File: tb/tb_rxCommitBuffer.sv
module tb_rxCommitBuffer;
  logic        clk = 0, rstN = 0;
  logic        cmdValid = 0, cmdIsRx = 1, cmdHasData = 1, wordValid = 0;
  logic [15:0] cmdWord = 0, wordIn = 0, hostWdata = 0;
  logic        msgDone = 0, msgAbort = 0, illegalN = 1;
  logic        hostReq = 0, hostWe = 0, txNext = 0;
  logic [7:0]  hostAddr = 0;
  logic [15:0] hostRdata, txData;
  logic        hostAckN, cmdStrobeN, fifoNotEmpty, fifoNotFull;

  always #10 clk = ~clk;

  rxCommitBuffer dut (.*);

  int checks = 0, fails = 0, strobeFalls = 0;
  logic prevStrobe = 1;
  bit finished = 0;
  logic [15:0] expRam [256];
  logic [15:0] expQ [64];
  int qHead = 0, qTail = 0;

  always @(negedge clk) begin
    if (prevStrobe && !cmdStrobeN) strobeFalls++;
    prevStrobe = cmdStrobeN;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendMsg(input logic [15:0] cmd, input bit isRx, input bit hasD,
                         input int n, input logic [7:0] seed, input int mode, input bit fin);
    @(negedge clk);
    cmdValid = 1; cmdWord = cmd; cmdIsRx = isRx; cmdHasData = hasD;
    @(negedge clk);
    cmdValid = 0;
    for (int i = 0; i < n; i++) begin
      wordValid = 1; wordIn = {seed, 8'(i)};
      @(negedge clk);
    end
    wordValid = 0;
    if (fin) begin
      if (mode == 2) msgAbort = 1; else msgDone = 1;
      illegalN = (mode != 1);
      @(negedge clk);
      msgDone = 0; msgAbort = 0; illegalN = 1;
    end
  endtask

  task automatic hostXfer(input bit we, input logic [7:0] addr, input logic [15:0] wd,
                          output logic [15:0] rd);
    @(negedge clk);
    hostReq = 1; hostWe = we; hostAddr = addr; hostWdata = wd;
    while (hostAckN) @(negedge clk);
    rd = hostRdata; hostReq = 0;
    while (!hostAckN) @(negedge clk);
  endtask

  // seed[31:24] n[23:18] mode[17:16] (0 legal,1 illegal,2 abort) cmd[15:0]
  localparam logic [31:0] VEC [5] = '{
    {8'h11, 6'd3,  2'd0, 16'h0823},
    {8'h22, 6'd32, 2'd0, 16'h0840},
    {8'h33, 6'd5,  2'd1, 16'h0860},
    {8'h44, 6'd4,  2'd2, 16'h0880},
    {8'h55, 6'd2,  2'd0, 16'h0820}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int c, d, lowA, falls0;
    for (int i = 0; i < 256; i++) expRam[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobe", cmdStrobeN, 1);
    chk("R1 ack", hostAckN, 1);
    chk("R1 notEmpty", fifoNotEmpty, 0);
    chk("R1 notFull", fifoNotFull, 1);

    // Table: R2 commit / abort, R3 illegal
    foreach (VEC[v]) begin
      logic [15:0] cmd; int n, mode; logic [7:0] seed; logic [7:0] base;
      cmd = VEC[v][15:0]; mode = VEC[v][17:16]; n = VEC[v][23:18]; seed = VEC[v][31:24];
      if (n == 0) n = 32;
      base = {cmd[7:5], 5'd0};
      falls0 = strobeFalls;
      sendMsg(cmd, 1, 1, n, seed, mode, 1);
      repeat (136 + 16 * n + 10) @(negedge clk);
      if (mode == 0) begin
        for (int i = 0; i < n; i++) expRam[base + 8'(i)] = {seed, 8'(i)};
        expQ[qTail] = cmd; qTail++;
      end
      chk(mode == 0 ? "R2 strobe count" : "R3 no strobe", strobeFalls - falls0, mode == 0 ? 1 : 0);
      for (int i = 0; i < n; i++) begin
        hostXfer(0, base + 8'(i), 0, rd);
        chk(mode == 1 ? "R3 ram untouched" : "R2 ram word", rd, expRam[base + 8'(i)]);
      end
    end

    // R4 / R6: strobe length and late host request waits for the burst
    sendMsg(16'h08A0, 1, 1, 3, 8'h77, 0, 0);
    msgDone = 1;
    @(negedge clk);
    msgDone = 0;
    chk("R4 strobe low next cycle", cmdStrobeN, 0);
    hostReq = 1; hostWe = 0; hostAddr = 8'hA0;
    c = 0;
    while (!cmdStrobeN) begin
      c++;
      if (!hostAckN) chk("R6 no ack in strobe", hostAckN, 1);
      @(negedge clk);
    end
    chk("R4 strobe length", c, 136);
    d = 0;
    while (hostAckN) begin @(negedge clk); d++; end
    chk("R6 ack after 3-word burst", d, 49);
    for (int i = 0; i < 3; i++) expRam[8'hA0 + 8'(i)] = {8'h77, 8'(i)};
    chk("R4 committed word", hostRdata, expRam[8'hA0]);
    hostReq = 0;
    while (!hostAckN) @(negedge clk);
    expQ[qTail] = 16'h08A0; qTail++;

    // R5: request pending at strobe start is granted during the strobe
    sendMsg(16'h08C0, 1, 1, 2, 8'h66, 0, 0);
    hostReq = 1; hostWe = 0; hostAddr = 8'h21;
    @(negedge clk);
    chk("R5 ack after grant", hostAckN, 0);
    chk("R5 read A", hostRdata, expRam[8'h21]);
    hostReq = 0; lowA = 1;
    @(negedge clk);
    if (!hostAckN) lowA++;
    hostReq = 1; hostAddr = 8'h22; msgDone = 1;
    @(negedge clk);
    msgDone = 0;
    while (!hostAckN) begin lowA++; @(negedge clk); end
    chk("R5 ack pulse length", lowA, 8);
    while (hostAckN) @(negedge clk);
    chk("R5 early request granted in strobe", cmdStrobeN, 0);
    chk("R5 read B", hostRdata, expRam[8'h22]);
    hostReq = 0;
    while (!hostAckN) @(negedge clk);
    repeat (136 + 32 + 20) @(negedge clk);
    expRam[8'hC0] = 16'h6600; expRam[8'hC1] = 16'h6601;
    expQ[qTail] = 16'h08C0; qTail++;
    hostXfer(0, 8'hC1, 0, rd);
    chk("R2 blk6 word1", rd, 16'h6601);

    // R8: command without data
    falls0 = strobeFalls;
    sendMsg(16'h08E0, 1, 0, 1, 8'h99, 0, 1);
    repeat (150) @(negedge clk);
    chk("R8 no strobe", strobeFalls - falls0, 0);

    // R11: direct host access
    hostXfer(1, 8'h55, 16'hBEEF, rd);
    hostXfer(0, 8'h55, 0, rd);
    chk("R11 readback", rd, 16'hBEEF);

    // R10: transmit copies RAM into buffer
    for (int i = 0; i < 3; i++) hostXfer(1, 8'hE0 + 8'(i), 16'hA000 + 16'(i), rd);
    sendMsg(16'h08E3, 0, 1, 0, 8'h00, 0, 1);
    repeat (136 + 48 + 20) @(negedge clk);
    expQ[qTail] = 16'h08E3; qTail++;
    for (int i = 0; i < 3; i++) begin
      chk("R10 tx word", txData, 16'hA000 + 16'(i));
      txNext = 1; @(negedge clk); txNext = 0; @(negedge clk);
    end

    // R9 / R7: drain FIFO in order, then empty read
    while (qHead < qTail) begin
      hostXfer(0, 8'h00, 0, rd);
      chk("R9 fifo order", rd, expQ[qHead]); qHead++;
    end
    chk("R7 empty after drain", fifoNotEmpty, 0);
    hostXfer(0, 8'h00, 0, rd);
    chk("R9 empty read zero", rd, 0);
    chk("R9 empty stays empty", fifoNotEmpty, 0);

    // R7: fill to 32, 33rd dropped
    for (int i = 0; i < 33; i++) begin
      sendMsg(16'h1000 + 16'(i), 1, 1, 1, 8'(i), 0, 1);
      repeat (136 + 16 + 12) @(negedge clk);
      if (i == 31) chk("R7 full at 32", fifoNotFull, 0);
    end
    chk("R7 full after drop", fifoNotFull, 0);
    chk("R7 not empty", fifoNotEmpty, 1);
    for (int i = 0; i < 32; i++) begin
      hostXfer(0, 8'h00, 0, rd);
      chk("R7 fifo entry", rd, 16'h1000 + 16'(i));
      if (i == 0) chk("R7 not full after pop", fifoNotFull, 1);
    end
    chk("R7 33rd dropped", fifoNotEmpty, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule